// File: doc/BRIEF.md
# Programmable Input Glitch Filter

This block cleans up one asynchronous digital input before it reaches an edge detector. The raw level first passes through a two-stage synchronizer on the system clock. A new level is accepted only after it has held steady for a programmed number of filter ticks. Any shorter excursion is dropped as a glitch.

A filter tick is either every system clock cycle or a one-cycle enable pulse from an external prescaler. A select input chooses between the two. A 4-bit one-hot threshold field sets how many ticks of stability a new level needs. Zero, or any pattern that is not one-hot, turns the qualification off, so the output follows the synchronized input one register later. There is no freeze or global-enable gating: the filter runs whenever it is clocked and out of reset.

Top module: `din_glitch_filter`

## Requirements
- R1: The raw input is sampled by a two-flop synchronizer. In bypass, a change on raw_i appears on filt_o at the third rising clock edge after it is applied.
- R2: While rst_ni is low (asynchronous, active low), filt_o is 0 and the qualification count is 0.
- R3: The threshold field thr_sel_i gives N stable ticks: 4'b0001 gives 2, 4'b0010 gives 4, 4'b0100 gives 8, 4'b1000 gives 16. With tick_sel_i = 0 (a tick every cycle), a held change on raw_i reaches filt_o at rising edge N+2 after it is applied.
- R4: An input level that differs from filt_o for N-1 ticks never reaches filt_o. A level that holds for N ticks does reach it.
- R5: With tick_sel_i = 1, only cycles with ext_tick_i = 1 count as ticks. With no such pulse, filt_o does not change in filter mode.
- R6: If the synchronized input returns to the filt_o level before N ticks, the count clears to zero. A later change counts from zero again.
- R7: thr_sel_i = 4'b0000, or any value that is not one-hot, is bypass: filt_o takes the synchronized input on every clock.
- R8: Any change of thr_sel_i or tick_sel_i clears the count. A qualification in progress then restarts from zero under the new setting.
- R9: filt_o only ever changes to the level the synchronizer held in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_i | input | 1 | Asynchronous input to be filtered |
| tick_sel_i | input | 1 | Tick source: 0 = every clock, 1 = ext_tick_i |
| ext_tick_i | input | 1 | Clock-enable pulse from an external prescaler |
| thr_sel_i | input | 4 | One-hot stability threshold; other values bypass |
| filt_o | output | 1 | Filtered level for the downstream edge detector |

## Verification
A miscount in the qualification counter shows up as a shift in the edge at which filt_o moves. The bench checks that edge exactly, so an error of one cycle is caught on the first qualified change. A counter that fails to clear on a reversal or on a configuration change makes a later pulse pass too early. A wrong tick gate lets filt_o move while no prescaler pulse arrives. Each of these is visible within one threshold period, at most eighteen clocks after the stimulus.

// File: rtl/dgf_pkg.sv
package dgf_pkg;
  localparam int unsigned THR_W_DEF = 4;
  localparam int unsigned CNT_W_DEF = 5;
  localparam int unsigned SYNC_DEF  = 2;

  typedef enum logic {
    TICK_SYS = 1'b0,
    TICK_EXT = 1'b1
  } tick_src_e;
endpackage

// File: rtl/dgf_sync.sv
module dgf_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dgf_cfg.sv
module dgf_cfg
  import dgf_pkg::*;
#(
  parameter int unsigned THR_W = THR_W_DEF,
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [THR_W-1:0] thr_i,
  input  logic             sel_i,
  input  logic             ext_tick_i,
  output logic             tick_o,
  output logic             bypass_o,
  output logic [CNT_W-1:0] lim_o,
  output logic             chg_o
);
  logic [THR_W-1:0] thr_q;
  logic             sel_q;

  // terminal count = N-1 where N = 2^(i+1) for one-hot bit i
  always_comb begin
    lim_o = '0;
    for (int i = 0; i < THR_W; i++)
      if (thr_i[i]) lim_o = CNT_W'((1 << (i + 1)) - 1);
  end

  assign bypass_o = !$onehot(thr_i);
  assign tick_o   = (tick_src_e'(sel_i) == TICK_EXT) ? ext_tick_i : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      thr_q <= '0;
      sel_q <= 1'b0;
    end else begin
      thr_q <= thr_i;
      sel_q <= sel_i;
    end

  assign chg_o = (thr_i != thr_q) || (sel_i != sel_q);
endmodule

// File: rtl/dgf_qual.sv
module dgf_qual #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic             tick_i,
  input  logic             bypass_i,
  input  logic [CNT_W-1:0] lim_i,
  input  logic             chg_i,
  output logic             filt_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             filt_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (bypass_i) begin
      filt_q <= sync_i;
      cnt_q  <= '0;
    end else if (chg_i || (sync_i == filt_q)) begin
      cnt_q  <= '0;
    end else if (tick_i) begin
      if (cnt_q == lim_i) begin
        filt_q <= sync_i;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end

  assign filt_o = filt_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/din_glitch_filter.sv
module din_glitch_filter
  import dgf_pkg::*;
#(
  parameter int unsigned THR_W  = THR_W_DEF,
  parameter int unsigned SYNC_N = SYNC_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raw_i,
  input  logic             tick_sel_i,
  input  logic             ext_tick_i,
  input  logic [THR_W-1:0] thr_sel_i,
  output logic             filt_o
);
  localparam int unsigned CNT_W = THR_W + 1;

  logic             sync_q;
  logic             tick;
  logic             bypass;
  logic             cfg_chg;
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] cnt_q;

  dgf_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_i),
    .q_o   (sync_q)
  );

  dgf_cfg #(.THR_W(THR_W), .CNT_W(CNT_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .thr_i     (thr_sel_i),
    .sel_i     (tick_sel_i),
    .ext_tick_i(ext_tick_i),
    .tick_o    (tick),
    .bypass_o  (bypass),
    .lim_o     (lim),
    .chg_o     (cfg_chg)
  );

  dgf_qual #(.CNT_W(CNT_W)) u_qual (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_i  (sync_q),
    .tick_i  (tick),
    .bypass_i(bypass),
    .lim_i   (lim),
    .chg_i   (cfg_chg),
    .filt_o  (filt_o),
    .cnt_o   (cnt_q)
  );
endmodule

// File: rtl/dgf_chk.sv
module dgf_chk #(
  parameter int unsigned CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             filt_i,
  input logic             sync_i,
  input logic             tick_i,
  input logic             bypass_i,
  input logic             chg_i,
  input logic [CNT_W-1:0] lim_i,
  input logic [CNT_W-1:0] cnt_i
);
  p_reset_clear_r2: assert property (@(posedge clk_i)
    !rst_ni |-> (!filt_i && cnt_i == '0));

  p_fire_at_limit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(filt_i) && !$past(bypass_i)) |->
      ($past(cnt_i) == $past(lim_i) && $past(tick_i) && !$past(chg_i)));

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chg_i |-> (cnt_i <= lim_i));

  p_no_tick_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(bypass_i) && !$past(tick_i)) |-> $stable(filt_i));

  p_reversal_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sync_i == filt_i) |-> (cnt_i == '0));

  p_cfg_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(chg_i) |-> (cnt_i == '0));

  p_follow_sync_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_i) |-> (filt_i == $past(sync_i)));
endmodule

bind din_glitch_filter dgf_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .filt_i  (filt_o),
  .sync_i  (sync_q),
  .tick_i  (tick),
  .bypass_i(bypass),
  .chg_i   (cfg_chg),
  .lim_i   (lim),
  .cnt_i   (cnt_q)
);

// File: tb/din_glitch_filter_tb.sv
module din_glitch_filter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  typedef struct packed {
    logic [3:0] thr;
    logic [7:0] len;
    logic [7:0] lat;  // 0 = pulse must be suppressed
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{4'b0001, 8'd1,  8'd0},   // R4 N-1
    '{4'b0001, 8'd2,  8'd4},   // R3/R4 N
    '{4'b0010, 8'd3,  8'd0},
    '{4'b0010, 8'd4,  8'd6},
    '{4'b0100, 8'd7,  8'd0},
    '{4'b0100, 8'd8,  8'd10},
    '{4'b1000, 8'd15, 8'd0},
    '{4'b1000, 8'd16, 8'd18},
    '{4'b1000, 8'd20, 8'd18},
    '{4'b0000, 8'd1,  8'd3},   // R7/R1 bypass
    '{4'b0110, 8'd1,  8'd3},   // R7 not one-hot
    '{4'b0001, 8'd5,  8'd4}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       raw_i = 1'b0;
  logic       tick_sel_i = 1'b0;
  logic       ext_tick_i = 1'b0;
  logic [3:0] thr_sel_i = 4'b0000;
  logic       filt_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  din_glitch_filter u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .raw_i     (raw_i),
    .tick_sel_i(tick_sel_i),
    .ext_tick_i(ext_tick_i),
    .thr_sel_i (thr_sel_i),
    .filt_o    (filt_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      summary();
    end
  end

  initial begin
    int first;
    wait_clks(3);
    chk(filt_o == 1'b0, "R2 reset level", filt_o, 0);
    rst_ni = 1'b1;
    wait_clks(2);

    // table of pulses, tick every clock
    for (int v = 0; v < NVEC; v++) begin
      thr_sel_i = VECS[v].thr;
      wait_clks(4);
      raw_i = 1'b1;
      first = 0;
      for (int m = 1; m <= 60; m++) begin
        @(negedge clk_i);
        if (filt_o && first == 0) first = m;
        if (m == int'(VECS[v].len)) raw_i = 1'b0;
      end
      chk(first == int'(VECS[v].lat), "R3/R4/R7 first rise edge", first, int'(VECS[v].lat));
      chk(filt_o == 1'b0, "R4 returns low", filt_o, 0);
    end

    // R6: reversal restarts count (N=8)
    thr_sel_i = 4'b0100;
    wait_clks(4);
    raw_i = 1'b1;
    first = 0;
    for (int m = 1; m <= 40; m++) begin
      @(negedge clk_i);
      if (filt_o && first == 0) first = m;
      if (m == 5) raw_i = 1'b0;
      if (m == 7) raw_i = 1'b1;
    end
    chk(first == 17, "R6 restart after reversal", first, 17);
    raw_i = 1'b0;
    wait_clks(30);

    // R8: threshold change mid-qualification (16 -> 8)
    thr_sel_i = 4'b1000;
    wait_clks(4);
    raw_i = 1'b1;
    first = 0;
    for (int m = 1; m <= 40; m++) begin
      @(negedge clk_i);
      if (filt_o && first == 0) first = m;
      if (m == 10) thr_sel_i = 4'b0100;
    end
    chk(first == 19, "R8 count cleared on cfg change", first, 19);
    raw_i = 1'b0;
    wait_clks(30);
    chk(filt_o == 1'b0, "R8 back low", filt_o, 0);

    // R5: external tick source, N=2
    thr_sel_i = 4'b0001;
    tick_sel_i = 1'b1;
    wait_clks(4);
    raw_i = 1'b1;
    wait_clks(20);
    chk(filt_o == 1'b0, "R5 no tick no change", filt_o, 0);
    ext_tick_i = 1'b1;
    @(negedge clk_i);
    ext_tick_i = 1'b0;
    wait_clks(3);
    chk(filt_o == 1'b0, "R5 one tick not enough", filt_o, 0);
    ext_tick_i = 1'b1;
    @(negedge clk_i);
    ext_tick_i = 1'b0;
    chk(filt_o == 1'b1, "R5 second tick qualifies", filt_o, 1);

    // R2: asynchronous reset while high
    #(CLK_PERIOD/4);
    rst_ni = 1'b0;
    #1;
    chk(filt_o == 1'b0, "R2 async reset clears", filt_o, 0);
    raw_i = 1'b0;
    tick_sel_i = 1'b0;
    wait_clks(2);
    rst_ni = 1'b1;
    wait_clks(5);
    chk(filt_o == 1'b0, "R2 low after release", filt_o, 0);

    done = 1'b1;
    summary();
  end
endmodule